// File: doc/BRIEF.md
# Serial Management Register Slave for a 10/100 PHY

This block is the management endpoint of a twin-speed Ethernet transceiver. It runs entirely on the management clock, watches the management data line bit by bit, and decodes two-wire management frames. These are a run of ones, a start pattern, an opcode, a PHY address, a register address, a turnaround and 16 data bits. Only frames aimed at its own PHY address are served. For a read, it takes over the data line for the turnaround and data bits. For a write, it updates its small register file at the last data bit.

The register file holds these registers:
- a writable control word, which drives the isolate and power-down outputs;
- a status word whose link bit latches low;
- two identifier words;
- a PHY status word with a live, non-latching copy of the link state;
- a saturating receive error counter;
- a PHY control word holding the station address.

The address comes from five strap pins, captured while hardware reset is held. A strap value of zero isolates the port. Writing zero into the address field later does not isolate it. The data line is split into input, output and output-enable, and the pad is built outside the block.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: While `rst_n` is low the slave copies `strap_addr` into its station address, which reads back in bits 4:0 of register 19h. The slave answers only frames whose PHY address field equals the current station address. For any other frame, `mdio_oe` stays low and no register changes. A write to register 19h replaces the station address used by later frames.
- R2: `isolate` is high after reset when `strap_addr` was 0 at reset. Writing 0 to the address field of register 19h never raises `isolate`.
- R3: In a read, `mdio_oe` is low during the first turnaround bit time. During the second it is high with `mdio_o` = 0. The 16 data bits follow, MSB first, one per clock, and then `mdio_oe` drops. Each value changes after a rising clock edge, so the station samples it on the next rising edge.
- R4: A frame is recognised only after at least 32 consecutive ones have been sampled, followed by 0 then 1. The opcode 10 means read and 01 means write. A frame with a broken start, a short preamble, or opcode 00 or 11 is ignored: no drive and no write.
- R5: Register 00h is fully readable and writable and resets to 3100h. Its bit 10 is ORed with the strap isolate to form `isolate`, and its bit 11 drives `power_down`. Management access keeps working while either bit is set.
- R6: Register 01h returns fixed capability bits (7809h by default), with bit 2 as the latched link bit. That bit resets to 0 and clears in any clock where `link_live` is low. A read of 01h returns the latched value and then reloads the bit from `link_live`.
- R7: Register 10h bit 0 returns `link_live` directly, and its other bits are zero. Reading 10h never changes the latched link bit of 01h.
- R8: Register 15h holds an 8-bit receive error count in bits 7:0, with upper bits 0. The count rises by one on each clock where `rx_err` is high, stops at FFh, resets to 0 and ignores writes.
- R9: Registers 02h and 03h return the two identifier parameters. Unmapped addresses read as 0, and writes to registers other than 00h and 19h are ignored.
- R10: A write takes effect at the rising edge that samples the last data bit. Its effect is visible on the outputs right after that edge and in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock, rising edge samples the data line |
| rst_n | input | 1 | Hardware reset, active low, asynchronous; straps are captured while low |
| strap_addr | input | 5 | Strap pins giving the station address |
| mdio_i | input | 1 | Data line as seen at the pad |
| mdio_o | output | 1 | Data value driven during reads |
| mdio_oe | output | 1 | Output enable for the data line pad |
| link_live | input | 1 | Current link state from the PHY core |
| rx_err | input | 1 | One-clock receive error indication |
| isolate | output | 1 | Isolates the data interface from the MAC |
| power_down | output | 1 | Powers down everything except the register file |

## Verification
The bench aims at the turnaround bit by bit. A slave that drives one bit early would collide with the station on the first turnaround bit, and one a bit late would shift the whole read word by one. Frames with 31 ones, a 00 start or an illegal opcode are sent, because a parser that is too lenient would write the control word from noise. The latched link bit is tested by dropping and restoring the link between reads, and by reading the live copy in between; a design that re-armed on the wrong read would lose the link-loss event. Zero is written into the address field under a non-zero strap to catch a design that ties isolation to the live address instead of the strap.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

   localparam int REG_W  = 16;
   localparam int ADDR_W = 5;

   typedef enum logic [2:0] {
      ST_PRE,
      ST_START,
      ST_HDR,
      ST_TA,
      ST_DATA
   } frm_state_e;

   localparam logic [1:0] OP_RD = 2'b10;
   localparam logic [1:0] OP_WR = 2'b01;

   localparam logic [ADDR_W-1:0] RA_CTRL  = 5'h00;
   localparam logic [ADDR_W-1:0] RA_STAT  = 5'h01;
   localparam logic [ADDR_W-1:0] RA_ID_HI = 5'h02;
   localparam logic [ADDR_W-1:0] RA_ID_LO = 5'h03;
   localparam logic [ADDR_W-1:0] RA_PSTS  = 5'h10;
   localparam logic [ADDR_W-1:0] RA_RXERR = 5'h15;
   localparam logic [ADDR_W-1:0] RA_PCTL  = 5'h19;

   localparam int CTRL_ISO_BIT  = 10;
   localparam int CTRL_PD_BIT   = 11;
   localparam int STAT_LINK_BIT = 2;

endpackage

// File: rtl/mdio_err_cnt.sv
module mdio_err_cnt #(
   parameter int CNT_W   = 8,
   parameter bit CNT_SAT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;

   generate
      if (CNT_SAT) begin : g_sat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (inc && cnt_q != CNT_MAX)
               cnt_q <= cnt_q + 1'b1;
         end

         a_r8_saturate : assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q == CNT_MAX && inc) |=> (cnt_q == CNT_MAX));
      end else begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (inc)
               cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate

   a_r8_step : assert property (@(posedge clk) disable iff (!rst_n)
      (!inc) |=> $stable(cnt_q));

   assign cnt = cnt_q;

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
   import mdio_pkg::*;
#(
   parameter int PRE_MIN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mdio_i,
   input  logic [ADDR_W-1:0] my_addr,
   input  logic [REG_W-1:0]  rd_data,
   output logic              rd_req,
   output logic [ADDR_W-1:0] reg_addr,
   output logic              wr_en,
   output logic [REG_W-1:0]  wr_data,
   output logic              mdio_o,
   output logic              mdio_oe
);

   localparam int PRE_W = $clog2(PRE_MIN + 1);
   localparam logic [PRE_W-1:0] PRE_FULL = PRE_W'(PRE_MIN);
   localparam int HDR_W = 2 + 2 * ADDR_W;
   localparam logic [3:0] HDR_LAST = 4'(HDR_W - 1);
   localparam logic [3:0] DAT_LAST = 4'(REG_W - 1);

   frm_state_e        state_q;
   logic [PRE_W-1:0]  pre_q;
   logic [HDR_W-2:0]  hdr_q;
   logic [3:0]        bit_q;
   logic              is_rd_q;
   logic [REG_W-1:0]  shift_q;
   logic              oe_q, o_q;

   logic [HDR_W-1:0]  hdr_nx;
   logic              hdr_end, hit, op_rd, op_wr;

   assign hdr_nx  = {hdr_q, mdio_i};
   assign hdr_end = (state_q == ST_HDR) && (bit_q == HDR_LAST);
   assign hit     = (hdr_nx[2*ADDR_W-1:ADDR_W] == my_addr);
   assign op_rd   = (hdr_nx[HDR_W-1:HDR_W-2] == OP_RD);
   assign op_wr   = (hdr_nx[HDR_W-1:HDR_W-2] == OP_WR);

   assign rd_req   = hdr_end && hit && op_rd;
   assign reg_addr = (state_q == ST_HDR) ? hdr_nx[ADDR_W-1:0] : hdr_q[ADDR_W-1:0];
   assign wr_data  = {shift_q[REG_W-2:0], mdio_i};
   assign wr_en    = (state_q == ST_DATA) && !is_rd_q && (bit_q == DAT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_PRE;
         pre_q   <= '0;
         hdr_q   <= '0;
         bit_q   <= '0;
         is_rd_q <= 1'b0;
         shift_q <= '0;
         oe_q    <= 1'b0;
         o_q     <= 1'b0;
      end else begin
         unique case (state_q)
            ST_PRE: begin
               if (mdio_i) begin
                  if (pre_q != PRE_FULL) pre_q <= pre_q + 1'b1;
               end else if (pre_q == PRE_FULL) begin
                  pre_q   <= '0;
                  state_q <= ST_START;
               end else begin
                  pre_q <= '0;
               end
            end
            ST_START: begin
               bit_q   <= '0;
               state_q <= mdio_i ? ST_HDR : ST_PRE;
            end
            ST_HDR: begin
               hdr_q <= hdr_nx[HDR_W-2:0];
               bit_q <= bit_q + 1'b1;
               if (hdr_end) begin
                  bit_q <= '0;
                  if (hit && (op_rd || op_wr)) begin
                     state_q <= ST_TA;
                     is_rd_q <= op_rd;
                     if (op_rd) shift_q <= rd_data;
                  end else begin
                     state_q <= ST_PRE;
                  end
               end
            end
            ST_TA: begin
               bit_q <= bit_q + 1'b1;
               if (bit_q == 4'd0) begin
                  if (is_rd_q) begin
                     oe_q <= 1'b1;
                     o_q  <= 1'b0;
                  end
               end else begin
                  bit_q   <= '0;
                  state_q <= ST_DATA;
                  if (is_rd_q) begin
                     o_q     <= shift_q[REG_W-1];
                     shift_q <= {shift_q[REG_W-2:0], 1'b0};
                  end
               end
            end
            ST_DATA: begin
               bit_q <= bit_q + 1'b1;
               if (is_rd_q) begin
                  if (bit_q == DAT_LAST) begin
                     oe_q    <= 1'b0;
                     o_q     <= 1'b0;
                     state_q <= ST_PRE;
                  end else begin
                     o_q     <= shift_q[REG_W-1];
                     shift_q <= {shift_q[REG_W-2:0], 1'b0};
                  end
               end else begin
                  shift_q <= wr_data;
                  if (bit_q == DAT_LAST) state_q <= ST_PRE;
               end
            end
            default: state_q <= ST_PRE;
         endcase
      end
   end

   assign mdio_o  = o_q;
   assign mdio_oe = oe_q;

   a_r3_ta_zero : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdio_oe) |-> !mdio_o);

   a_r1_quiet_outside : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PRE || state_q == ST_START || state_q == ST_HDR) |-> !mdio_oe);

   a_r4_write_no_drive : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DATA && !is_rd_q) |-> !mdio_oe);

endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
   import mdio_pkg::*;
#(
   parameter logic [REG_W-1:0] STAT_CAPS = 16'h7809,
   parameter logic [REG_W-1:0] ID_HI     = 16'h1C5A,
   parameter logic [REG_W-1:0] ID_LO     = 16'h5E21,
   parameter logic [REG_W-1:0] CTRL_RST  = 16'h3100,
   parameter int               CNT_W     = 8,
   parameter bit               CNT_SAT   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] strap_addr,
   input  logic              link_live,
   input  logic              rx_err,
   input  logic              rd_req,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  rd_data,
   output logic [ADDR_W-1:0] my_addr,
   output logic              isolate,
   output logic              power_down
);

   logic [REG_W-1:0]  ctrl_q;
   logic [ADDR_W-1:0] phyad_q;
   logic              strap_iso_q;
   logic              link_lat_q;
   logic [CNT_W-1:0]  err_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q      <= CTRL_RST;
         phyad_q     <= strap_addr;
         strap_iso_q <= (strap_addr == '0);
      end else if (wr_en) begin
         if (reg_addr == RA_CTRL) ctrl_q  <= wr_data;
         if (reg_addr == RA_PCTL) phyad_q <= wr_data[ADDR_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         link_lat_q <= 1'b0;
      else if (rd_req && reg_addr == RA_STAT)
         link_lat_q <= link_live;
      else
         link_lat_q <= link_lat_q & link_live;
   end

   mdio_err_cnt #(
      .CNT_W   (CNT_W),
      .CNT_SAT (CNT_SAT)
   ) u_err_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (rx_err),
      .cnt   (err_cnt)
   );

   always_comb begin
      rd_data = '0;
      unique case (reg_addr)
         RA_CTRL:  rd_data = ctrl_q;
         RA_STAT: begin
            rd_data = STAT_CAPS;
            rd_data[STAT_LINK_BIT] = link_lat_q;
         end
         RA_ID_HI: rd_data = ID_HI;
         RA_ID_LO: rd_data = ID_LO;
         RA_PSTS:  rd_data[0] = link_live;
         RA_RXERR: rd_data = REG_W'(err_cnt);
         RA_PCTL:  rd_data[ADDR_W-1:0] = phyad_q;
         default:  rd_data = '0;
      endcase
   end

   assign my_addr    = phyad_q;
   assign isolate    = ctrl_q[CTRL_ISO_BIT] | strap_iso_q;
   assign power_down = ctrl_q[CTRL_PD_BIT];

   a_r7_link_latch : assert property (@(posedge clk) disable iff (!rst_n)
      !link_live |=> !link_lat_q);

   a_r6_rearm : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && reg_addr == RA_STAT && link_live) |=> link_lat_q);

   a_r2_pctl_no_iso : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_addr == RA_PCTL) |=> $stable(isolate));

endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
   import mdio_pkg::*;
#(
   parameter int               PRE_MIN   = 32,
   parameter logic [REG_W-1:0] STAT_CAPS = 16'h7809,
   parameter logic [REG_W-1:0] ID_HI     = 16'h1C5A,
   parameter logic [REG_W-1:0] ID_LO     = 16'h5E21,
   parameter logic [REG_W-1:0] CTRL_RST  = 16'h3100,
   parameter int               CNT_W     = 8,
   parameter bit               CNT_SAT   = 1'b1
) (
   input  logic       mdc,
   input  logic       rst_n,
   input  logic [4:0] strap_addr,
   input  logic       mdio_i,
   output logic       mdio_o,
   output logic       mdio_oe,
   input  logic       link_live,
   input  logic       rx_err,
   output logic       isolate,
   output logic       power_down
);

   generate
      if (PRE_MIN < 1) begin : g_bad_pre
         $error("PRE_MIN must be at least 1");
      end
      if (CNT_W < 1 || CNT_W > REG_W) begin : g_bad_cnt
         $error("CNT_W must lie in 1..16");
      end
      if (STAT_CAPS[STAT_LINK_BIT] != 1'b0) begin : g_bad_caps
         $error("STAT_CAPS must leave the link bit clear");
      end
      if (CTRL_RST[CTRL_PD_BIT] || CTRL_RST[CTRL_ISO_BIT]) begin : g_bad_ctrl
         $error("CTRL_RST must not isolate or power down");
      end
   endgenerate

   logic              rd_req, wr_en;
   logic [ADDR_W-1:0] reg_addr, my_addr;
   logic [REG_W-1:0]  rd_data, wr_data;

   mdio_frame #(
      .PRE_MIN (PRE_MIN)
   ) u_frame (
      .clk      (mdc),
      .rst_n    (rst_n),
      .mdio_i   (mdio_i),
      .my_addr  (my_addr),
      .rd_data  (rd_data),
      .rd_req   (rd_req),
      .reg_addr (reg_addr),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .mdio_o   (mdio_o),
      .mdio_oe  (mdio_oe)
   );

   mdio_regfile #(
      .STAT_CAPS (STAT_CAPS),
      .ID_HI     (ID_HI),
      .ID_LO     (ID_LO),
      .CTRL_RST  (CTRL_RST),
      .CNT_W     (CNT_W),
      .CNT_SAT   (CNT_SAT)
   ) u_regs (
      .clk        (mdc),
      .rst_n      (rst_n),
      .strap_addr (strap_addr),
      .link_live  (link_live),
      .rx_err     (rx_err),
      .rd_req     (rd_req),
      .reg_addr   (reg_addr),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .rd_data    (rd_data),
      .my_addr    (my_addr),
      .isolate    (isolate),
      .power_down (power_down)
   );

endmodule

// File: tb/mdio_mgmt_slave_test.sv
`timescale 1ns/100ps
module mdio_mgmt_slave_test;

   localparam logic [15:0] CAPS  = 16'h7809;
   localparam logic [15:0] IDH   = 16'h1C5A;
   localparam logic [15:0] IDL   = 16'h5E21;
   localparam logic [15:0] CRST  = 16'h3100;

   logic       mdc = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] strap_addr = 5'h0B;
   logic       mdio_i = 1'b1;
   logic       mdio_o, mdio_oe;
   logic       link_live = 1'b1;
   logic       rx_err = 1'b0;
   logic       isolate, power_down;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [15:0] m_ctrl;
   logic [4:0]  m_phy;
   logic        m_siso, m_lat;
   int          m_cnt;

   always #2.5 mdc = ~mdc;

   mdio_mgmt_slave #(
      .PRE_MIN (32), .STAT_CAPS (CAPS), .ID_HI (IDH), .ID_LO (IDL),
      .CTRL_RST (CRST), .CNT_W (8), .CNT_SAT (1'b1)
   ) uut (
      .mdc (mdc), .rst_n (rst_n), .strap_addr (strap_addr),
      .mdio_i (mdio_i), .mdio_o (mdio_o), .mdio_oe (mdio_oe),
      .link_live (link_live), .rx_err (rx_err),
      .isolate (isolate), .power_down (power_down)
   );

   task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_rd(input logic [4:0] a);
      case (a)
         5'h00: return m_ctrl;
         5'h01: return CAPS | {13'b0, m_lat, 2'b0};
         5'h02: return IDH;
         5'h03: return IDL;
         5'h10: return {15'b0, link_live};
         5'h15: return 16'(m_cnt);
         5'h19: return {11'b0, m_phy};
         default: return 16'h0000;
      endcase
   endfunction

   task automatic send_bit(input logic b);
      @(negedge mdc);
      mdio_i = b;
   endtask

   task automatic send_bits(input logic [31:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
   endtask

   task automatic header(input int pre, input logic [1:0] st, input logic [1:0] op,
                         input logic [4:0] phy, input logic [4:0] ra);
      for (int i = 0; i < pre; i++) send_bit(1'b1);
      send_bits({18'b0, st, op, phy, ra}, 14);
   endtask

   task automatic mgmt_read(input logic [4:0] phy, input logic [4:0] ra,
                            output logic [15:0] val, output bit ta_ok);
      header(32, 2'b01, 2'b10, phy, ra);
      val = '0;
      @(negedge mdc); mdio_i = 1'b1; ta_ok = !mdio_oe;
      @(negedge mdc); ta_ok = ta_ok && mdio_oe && !mdio_o;
      for (int i = 0; i < 16; i++) begin
         @(negedge mdc);
         val = {val[14:0], mdio_o};
         ta_ok = ta_ok && mdio_oe;
      end
      @(negedge mdc); ta_ok = ta_ok && !mdio_oe;
   endtask

   task automatic read_chk(input logic [4:0] ra, input string req);
      logic [15:0] v, e;
      bit ta;
      e = exp_rd(ra);
      mgmt_read(m_phy, ra, v, ta);
      if (ra == 5'h01) m_lat = link_live;
      check(v == e, req, v, e);
      check(ta, "R3 turnaround/drive window", {15'b0, ta}, 16'h0001);
   endtask

   task automatic mgmt_write(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
      header(32, 2'b01, 2'b01, phy, ra);
      send_bits(32'b10, 2);
      send_bits({16'b0, d}, 16);
      @(negedge mdc); mdio_i = 1'b1;
   endtask

   task automatic write_mdl(input logic [4:0] ra, input logic [15:0] d);
      mgmt_write(m_phy, ra, d);
      if (ra == 5'h00) m_ctrl = d;
      if (ra == 5'h19) m_phy = d[4:0];
      check(isolate == (m_ctrl[10] | m_siso), "R2/R5/R10 isolate after write", {15'b0, isolate}, {15'b0, m_ctrl[10] | m_siso});
      check(power_down == m_ctrl[11], "R5/R10 power_down after write", {15'b0, power_down}, {15'b0, m_ctrl[11]});
   endtask

   task automatic quiet_read(input logic [4:0] phy, input logic [4:0] ra, input string req);
      bit q;
      header(32, 2'b01, 2'b10, phy, ra);
      q = 1'b1;
      for (int i = 0; i < 19; i++) begin
         @(negedge mdc); mdio_i = 1'b1;
         q = q && !mdio_oe;
      end
      check(q, req, {15'b0, !q}, 16'h0000);
   endtask

   task automatic do_reset(input logic [4:0] s);
      @(negedge mdc);
      rst_n = 1'b0; strap_addr = s; mdio_i = 1'b1; rx_err = 1'b0;
      repeat (3) @(negedge mdc);
      rst_n = 1'b1;
      m_ctrl = CRST; m_phy = s; m_siso = (s == 5'h00); m_lat = 1'b0; m_cnt = 0;
   endtask

   task automatic set_link(input logic v);
      @(negedge mdc); link_live = v;
      @(negedge mdc);
      if (!v) m_lat = 1'b0;
   endtask

   task automatic err_pulses(input int n);
      if (n > 0) begin
         @(negedge mdc); rx_err = 1'b1;
         repeat (n) @(negedge mdc);
         rx_err = 1'b0;
         m_cnt = (m_cnt + n > 255) ? 255 : m_cnt + n;
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge mdc);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

   initial begin
      logic [4:0] wrong;
      void'($urandom(32'h5EED_0042));
      do_reset(5'h0B);
      check(isolate == 1'b0, "R2 no isolate with strap 0B", {15'b0, isolate}, 16'h0000);
      check(power_down == 1'b0, "R5 power_down reset", {15'b0, power_down}, 16'h0000);
      check(mdio_oe == 1'b0, "R3 idle release", {15'b0, mdio_oe}, 16'h0000);
      read_chk(5'h19, "R1 strap address readback");
      read_chk(5'h00, "R5 control reset value");
      read_chk(5'h02, "R9 id high");
      read_chk(5'h03, "R9 id low");
      read_chk(5'h07, "R9 unmapped reads 0");
      read_chk(5'h01, "R6 first status read latched 0");
      read_chk(5'h01, "R6 status rearmed");
      read_chk(5'h10, "R7 live link");
      // R7: live copy read must not rearm the latch
      set_link(1'b0);
      set_link(1'b1);
      read_chk(5'h10, "R7 live link after restore");
      read_chk(5'h01, "R7 latch kept low across live read");
      read_chk(5'h01, "R6 latch reloaded");
      // R5 control bits
      write_mdl(5'h00, 16'h0400);
      read_chk(5'h00, "R5 management works while isolated");
      write_mdl(5'h00, 16'h0800);
      read_chk(5'h00, "R5 management works while powered down");
      write_mdl(5'h00, CRST);
      // R8 counter
      err_pulses(10);
      read_chk(5'h15, "R8 count 10");
      write_mdl(5'h15, 16'h0000);
      read_chk(5'h15, "R8/R9 write ignored");
      err_pulses(300);
      read_chk(5'h15, "R8 saturate");
      // R1 wrong address
      quiet_read(m_phy ^ 5'h04, 5'h00, "R1 foreign read not driven");
      mgmt_write(m_phy ^ 5'h04, 5'h00, 16'h0C00);
      read_chk(5'h00, "R1 foreign write ignored");
      // R4 malformed frames
      send_bits(32'b000, 3);
      header(32, 2'b00, 2'b01, m_phy, 5'h00);
      send_bits(32'b10, 2); send_bits(32'h0000_0C00, 16);
      read_chk(5'h00, "R4 bad start ignored");
      header(32, 2'b01, 2'b11, m_phy, 5'h00);
      send_bits(32'b10, 2); send_bits(32'h0000_0C00, 16);
      read_chk(5'h00, "R4 opcode 11 ignored");
      send_bits(32'b000, 3);
      header(31, 2'b01, 2'b01, m_phy, 5'h00);
      send_bits(32'b10, 2); send_bits(32'h0000_0C00, 16);
      read_chk(5'h00, "R4 short preamble ignored");
      // R2 writing 0 into address field
      write_mdl(5'h19, 16'h0000);
      check(isolate == 1'b0, "R2 address 0 by write no isolate", {15'b0, isolate}, 16'h0000);
      read_chk(5'h19, "R1 new address 0 answers");
      write_mdl(5'h19, 16'h0013);
      read_chk(5'h19, "R1 address moved to 13");
      // R2 strap zero
      do_reset(5'h00);
      check(isolate == 1'b1, "R2 strap 0 isolates", {15'b0, isolate}, 16'h0001);
      read_chk(5'h19, "R1 strap 0 readback");
      write_mdl(5'h00, 16'h0000);
      write_mdl(5'h19, 16'h0005);
      check(isolate == 1'b1, "R2 strap isolate persists", {15'b0, isolate}, 16'h0001);
      do_reset(5'h1A);
      // random mix
      for (int it = 0; it < 150; it++) begin
         int sel;
         sel = $urandom_range(0, 6);
         case (sel)
            0: begin
               logic [4:0] ra;
               case ($urandom_range(0, 7))
                  0: ra = 5'h00; 1: ra = 5'h01; 2: ra = 5'h02; 3: ra = 5'h03;
                  4: ra = 5'h10; 5: ra = 5'h15; 6: ra = 5'h19;
                  default: ra = 5'($urandom_range(0, 31));
               endcase
               read_chk(ra, "R9/R6/R8 random read");
            end
            1: write_mdl(5'h00, 16'($urandom_range(0, 65535)));
            2: write_mdl(5'h19, 16'($urandom_range(0, 65535)));
            3: set_link(1'($urandom_range(0, 1)));
            4: err_pulses($urandom_range(0, 40));
            5: begin
               wrong = m_phy ^ 5'($urandom_range(1, 31));
               if ($urandom_range(0, 1) == 0)
                  quiet_read(wrong, 5'h00, "R1 random foreign read");
               else
                  mgmt_write(wrong, 5'h00, 16'($urandom_range(0, 65535)));
            end
            default: write_mdl(($urandom_range(0, 1) == 0) ? 5'h01 : 5'h15, 16'($urandom_range(0, 65535)));
         endcase
      end
      read_chk(5'h00, "R10 final control");
      read_chk(5'h19, "R1 final address");
      done = 1'b1;
      summary();
   end

endmodule